// File: doc/BRIEF.md
# Card Bus Launch Edge Selector

This block is the output stage that drives the command line and the data lines of a memory-card host port. It decides on which edge of the card clock each outgoing bit changes. The three timing modes are half-cycle, full-cycle and double data rate. In half-cycle mode a bit is launched on the falling card-clock edge and captured on the next rising edge. In full-cycle mode a bit is launched on a rising edge and captured on the following rising edge. In double data rate mode the data lines change on every edge.

The block runs on an internal clock at twice the card-clock rate. The card-clock generator supplies a phase flag, `cclk_ph`. When this flag is 1, the card clock rises at the coming internal edge; when it is 0, the card clock falls there. The generator alternates the flag on every internal cycle. The mode comes from two control bits. The low-voltage signalling enable selects full-cycle timing, which the 200 MHz single-edge mode needs. With that enable clear, legacy and high-speed single-edge operation uses half-cycle timing. A separate double-rate flag overrides both.

Protocol framing, input sampling and tuning sit in other blocks. This block registers the line values and their output enables on the chosen edge.

Top module: `card_launch_sel`

## Requirements
- R1: While `rst_n` is low, all line outputs and all output enables are 0 and the active mode is half-cycle.
- R2: The requested mode is double data rate when `ddr_en` is 1, whatever `sig18_en` is. Otherwise it is full-cycle when `sig18_en` is 1 and half-cycle when `sig18_en` is 0.
- R3: In half-cycle mode, `cmd_o` and `dat_o` take `cmd_d` and `dat_d` only at internal edges where `cclk_ph` is 0, which are falling card-clock edges. At rising edges they hold.
- R4: In full-cycle mode, the lines take new values only at internal edges where `cclk_ph` is 1, which are rising card-clock edges. At falling edges they hold.
- R5: In double data rate mode, each rising edge loads `dat_d` onto `dat_o` and also captures `dat_d2`. The following falling edge puts that captured `dat_d2` on `dat_o`, whatever `dat_d2` is by then.
- R6: In double data rate mode, the command line launches on rising edges only and never on falling edges.
- R7: A change on `sig18_en` or `ddr_en` is taken into the active mode only at a rising card-clock edge. At a falling edge the previous mode still decides the launch.
- R8: A single-edge launch is skipped when the same line launched at the immediately preceding internal edge. As a result, no command or single-rate data value lasts less than one full card-clock cycle.
- R9: `cmd_oe` and `dat_oe` are updated on the same edges as their lines. In double data rate mode, `dat_oe` takes `dat_oe_d` at the rising edge and keeps that value through the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the card-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cclk_ph | input | 1 | 1: card clock rises at the coming edge; 0: it falls |
| sig18_en | input | 1 | Low-voltage signalling enable (selects full-cycle timing) |
| ddr_en | input | 1 | Double data rate request |
| cmd_d | input | 1 | Command bit to send |
| cmd_oe_d | input | 1 | Command output enable to send |
| dat_d | input | DAT_W | Data bits; the first bit of a cycle in double data rate mode |
| dat_d2 | input | DAT_W | Second data bits of a cycle in double data rate mode |
| dat_oe_d | input | 1 | Data output enable to send |
| cmd_o | output | 1 | Registered command line |
| cmd_oe | output | 1 | Registered command output enable |
| dat_o | output | DAT_W | Registered data lines |
| dat_oe | output | 1 | Registered data output enable |

## Verification
A wrong mode register shows up at the next card-clock edge: lines launch on the wrong polarity, so a value appears half a card cycle early or late. A value that changes on a rising edge in half-cycle mode is this failure. A bad gap counter either repeats a launch on consecutive internal edges or swallows a launch for a whole card cycle. A stale double-rate hold register puts the wrong second bit on the lines at the very next falling edge. Each of these shows within one or two internal clocks of the edge that triggers it.

// File: rtl/lsel_pkg.sv
`timescale 1ns/1ps
package lsel_pkg;
  typedef enum logic [1:0] {
    LM_HALF = 2'd0,
    LM_FULL = 2'd1,
    LM_DDR  = 2'd2
  } launch_mode_e;

  localparam int GAP_W = 2;
endpackage

// File: rtl/lsel_mode.sv
`timescale 1ns/1ps
module lsel_mode
  import lsel_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cclk_ph,
  input  logic         sig18_en,
  input  logic         ddr_en,
  output launch_mode_e mode_q,
  output launch_mode_e mode_eff
);
  launch_mode_e req;
  launch_mode_e mode_n;
  logic         mode_ce;

  always_comb begin
    if (ddr_en)        req = LM_DDR;
    else if (sig18_en) req = LM_FULL;
    else               req = LM_HALF;
  end

  // the mode may only move at a rising card-clock edge
  assign mode_ce  = cclk_ph;
  assign mode_n   = mode_ce ? req : mode_q;
  assign mode_eff = mode_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= LM_HALF;
    else if (mode_ce) mode_q <= mode_n;
  end
endmodule

// File: rtl/lsel_lane.sv
`timescale 1ns/1ps
module lsel_lane
  import lsel_pkg::*;
#(
  parameter int W       = 8,
  parameter bit DDR_CAP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  launch_mode_e mode,
  input  logic [W-1:0] d_first,
  input  logic [W-1:0] d_second,
  input  logic         oe_in,
  output logic [W-1:0] q,
  output logic         oe_q
);
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  logic [W-1:0]     q_n, hold, hold_n;
  logic             oe_n, oe_hold, oe_hold_n;
  logic [GAP_W-1:0] gap, gap_n;
  logic             ddr_now, sdr_edge, fire, hold_ce;

  always_comb begin
    ddr_now  = DDR_CAP && (mode == LM_DDR);
    sdr_edge = (mode == LM_HALF) ? !rise : rise;
    fire     = ddr_now || (sdr_edge && (gap != '0));
    hold_ce  = ddr_now && rise;

    q_n  = q;
    oe_n = oe_q;
    if (fire) begin
      if (ddr_now && !rise) begin
        q_n  = hold;
        oe_n = oe_hold;
      end else begin
        q_n  = d_first;
        oe_n = oe_in;
      end
    end

    hold_n    = hold_ce ? d_second : hold;
    oe_hold_n = hold_ce ? oe_in    : oe_hold;

    if (fire)                gap_n = '0;
    else if (gap == GAP_MAX) gap_n = gap;
    else                     gap_n = gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      oe_q    <= 1'b0;
      hold    <= '0;
      oe_hold <= 1'b0;
      gap     <= GAP_MAX;
    end else begin
      q       <= q_n;
      oe_q    <= oe_n;
      hold    <= hold_n;
      oe_hold <= oe_hold_n;
      gap     <= gap_n;
    end
  end
endmodule

// File: rtl/card_launch_sel.sv
`timescale 1ns/1ps
module card_launch_sel
  import lsel_pkg::*;
#(
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cclk_ph,
  input  logic             sig18_en,
  input  logic             ddr_en,
  input  logic             cmd_d,
  input  logic             cmd_oe_d,
  input  logic [DAT_W-1:0] dat_d,
  input  logic [DAT_W-1:0] dat_d2,
  input  logic             dat_oe_d,
  output logic             cmd_o,
  output logic             cmd_oe,
  output logic [DAT_W-1:0] dat_o,
  output logic             dat_oe
);
  launch_mode_e mode_q;
  launch_mode_e mode_eff;

  lsel_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cclk_ph  (cclk_ph),
    .sig18_en (sig18_en),
    .ddr_en   (ddr_en),
    .mode_q   (mode_q),
    .mode_eff (mode_eff)
  );

  // command stays single-rate; double rate maps to rising-edge launch
  lsel_lane #(.W(1), .DDR_CAP(1'b0)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (cclk_ph),
    .mode     (mode_eff),
    .d_first  (cmd_d),
    .d_second (cmd_d),
    .oe_in    (cmd_oe_d),
    .q        (cmd_o),
    .oe_q     (cmd_oe)
  );

  lsel_lane #(.W(DAT_W), .DDR_CAP(1'b1)) u_dat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (cclk_ph),
    .mode     (mode_eff),
    .d_first  (dat_d),
    .d_second (dat_d2),
    .oe_in    (dat_oe_d),
    .q        (dat_o),
    .oe_q     (dat_oe)
  );
endmodule

// File: rtl/lsel_chk.sv
`timescale 1ns/1ps
module lsel_chk
  import lsel_pkg::*;
#(
  parameter int DAT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cclk_ph,
  input logic [1:0]       mode_q,
  input logic [1:0]       mode_eff,
  input logic [DAT_W-1:0] dat_d,
  input logic [DAT_W-1:0] dat_o,
  input logic             dat_oe,
  input logic             cmd_o,
  input logic             cmd_oe
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (dat_o == '0 && !dat_oe && !cmd_o && !cmd_oe && mode_q == LM_HALF);
    end
  end

  // R3
  half_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_ph && mode_eff == LM_HALF) |=> ($stable(dat_o) && $stable(cmd_o) && $stable(dat_oe)));

  // R4
  full_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cclk_ph && mode_eff == LM_FULL) |=> ($stable(dat_o) && $stable(cmd_o) && $stable(cmd_oe)));

  // R5
  ddr_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_ph && mode_eff == LM_DDR) |=> (dat_o == $past(dat_d)));

  // R6
  ddr_cmd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cclk_ph && mode_eff == LM_DDR) |=> $stable(cmd_o));

  // R7
  mode_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_ph |=> $stable(mode_q));

  // R8
  cmd_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |=> $stable(cmd_o));
endmodule

bind card_launch_sel lsel_chk #(.DAT_W(DAT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cclk_ph  (cclk_ph),
  .mode_q   (mode_q),
  .mode_eff (mode_eff),
  .dat_d    (dat_d),
  .dat_o    (dat_o),
  .dat_oe   (dat_oe),
  .cmd_o    (cmd_o),
  .cmd_oe   (cmd_oe)
);

// File: tb/sim_card_launch_sel.sv
`timescale 1ns/1ps
module sim_card_launch_sel;
  localparam int DAT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cclk_ph;
  logic             sig18_en, ddr_en;
  logic             cmd_d, cmd_oe_d, dat_oe_d;
  logic [DAT_W-1:0] dat_d, dat_d2;
  logic             cmd_o, cmd_oe, dat_oe;
  logic [DAT_W-1:0] dat_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  nxt_ph = 1'b1;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  card_launch_sel #(.DAT_W(DAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cclk_ph(cclk_ph), .sig18_en(sig18_en), .ddr_en(ddr_en),
    .cmd_d(cmd_d), .cmd_oe_d(cmd_oe_d), .dat_d(dat_d), .dat_d2(dat_d2), .dat_oe_d(dat_oe_d),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .dat_o(dat_o), .dat_oe(dat_oe)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // one internal edge; the card clock rises there when nxt_ph is 1
  task automatic tick();
    cclk_ph = nxt_ph;
    @(posedge clk);
    @(negedge clk);
    nxt_ph = !nxt_ph;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cclk_ph = 1'b0; sig18_en = 1'b0; ddr_en = 1'b0;
    cmd_d = 1'b1; cmd_oe_d = 1'b1; dat_d = 8'hFF; dat_d2 = 8'hFF; dat_oe_d = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "dat_o in reset", 32'(dat_o), 32'h0);
    chk("R1", "enables in reset", {30'd0, cmd_oe, dat_oe}, 32'h0);
    chk("R1", "cmd_o in reset", 32'(cmd_o), 32'h0);
    rst_n = 1'b1;
    nxt_ph = 1'b1;
  endtask

  task automatic t_half();
    cmd_d = 1'b1; cmd_oe_d = 1'b1; dat_d = 8'hA5; dat_oe_d = 1'b1;
    tick(); // rise
    chk("R3", "half: no launch at rise", 32'(dat_o), 32'h00);
    chk("R9", "half: dat_oe not at rise", 32'(dat_oe), 32'h0);
    tick(); // fall
    chk("R3", "half: launch at fall", 32'(dat_o), 32'hA5);
    chk("R9", "half: enables at fall", {30'd0, cmd_oe, dat_oe}, 32'h3);
    chk("R3", "half: cmd at fall", 32'(cmd_o), 32'h1);
    dat_d = 8'h3C; dat_oe_d = 1'b0; cmd_d = 1'b0;
    tick(); // rise
    chk("R3", "half: data held at rise", 32'(dat_o), 32'hA5);
    chk("R9", "half: oe held at rise", 32'(dat_oe), 32'h1);
    tick(); // fall
    chk("R3", "half: second launch", 32'(dat_o), 32'h3C);
    chk("R9", "half: oe drops at fall", 32'(dat_oe), 32'h0);
  endtask

  task automatic t_full();
    sig18_en = 1'b1; dat_d = 8'h5A; dat_oe_d = 1'b1; cmd_d = 1'b1;
    tick(); // rise right after a fall launch
    chk("R8", "full: launch skipped after half-cycle gap", 32'(dat_o), 32'h3C);
    tick(); // fall
    chk("R4", "full: no launch at fall", 32'(dat_o), 32'h3C);
    tick(); // rise
    chk("R4", "full: launch at rise", 32'(dat_o), 32'h5A);
    chk("R2", "full: cmd at rise", 32'(cmd_o), 32'h1);
    chk("R9", "full: dat_oe at rise", 32'(dat_oe), 32'h1);
    dat_d = 8'hC3;
    tick(); // fall
    chk("R4", "full: data held at fall", 32'(dat_o), 32'h5A);
    tick(); // rise
    chk("R4", "full: next launch", 32'(dat_o), 32'hC3);
  endtask

  task automatic t_defer();
    sig18_en = 1'b0; dat_d = 8'h11;
    tick(); // fall, mode still full
    chk("R7", "request ignored at fall", 32'(dat_o), 32'hC3);
    tick(); // rise, half takes effect
    chk("R7", "half active at rise, no launch", 32'(dat_o), 32'hC3);
    tick(); // fall
    chk("R2", "half launch after boundary", 32'(dat_o), 32'h11);
  endtask

  task automatic t_ddr();
    ddr_en = 1'b1; sig18_en = 1'b1;
    dat_d = 8'h81; dat_d2 = 8'h7E; dat_oe_d = 1'b1; cmd_d = 1'b0; cmd_oe_d = 1'b1;
    tick(); // rise
    chk("R5", "ddr: first bit at rise", 32'(dat_o), 32'h81);
    chk("R2", "ddr overrides full", 32'(dat_o), 32'h81);
    chk("R8", "ddr: cmd skipped after half-cycle gap", 32'(cmd_o), 32'h1);
    dat_d = 8'h00; dat_d2 = 8'h00; dat_oe_d = 1'b0;
    tick(); // fall
    chk("R5", "ddr: captured second bit at fall", 32'(dat_o), 32'h7E);
    chk("R9", "ddr: dat_oe held through fall", 32'(dat_oe), 32'h1);
    chk("R6", "ddr: cmd not at fall", 32'(cmd_o), 32'h1);
    dat_d = 8'h42; dat_d2 = 8'h24; dat_oe_d = 1'b1;
    tick(); // rise
    chk("R5", "ddr: next first bit", 32'(dat_o), 32'h42);
    chk("R6", "ddr: cmd launch at rise", 32'(cmd_o), 32'h0);
    tick(); // fall
    chk("R5", "ddr: next second bit", 32'(dat_o), 32'h24);
  endtask

  task automatic t_exit();
    ddr_en = 1'b0; sig18_en = 1'b0; dat_d = 8'h99;
    tick(); // rise, half now
    chk("R3", "exit: no launch at rise", 32'(dat_o), 32'h24);
    tick(); // fall
    chk("R3", "exit: half launch at fall", 32'(dat_o), 32'h99);
  endtask

  initial begin
    t_reset();
    t_half();
    t_full();
    t_defer();
    t_ddr();
    t_exit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule